// File: doc/BRIEF.md
# AHB Memory Slave with a One-Entry Posted Write Buffer

This block is an AHB slave that fronts a small register array. A write whose protection attribute marks it bufferable (bit 2 of `hprot` high) is posted into a single-entry buffer and completes with no wait state. A non-bufferable write goes straight to the array at the end of its data phase. The buffer is written back to the array in any cycle with no active data phase. It is also written back during a wait state that the slave inserts when a write arrives while the buffer still holds an entry.

Reads always observe the newest data. The read data path compares the read word with the buffered word and overlays the buffered byte lanes. A read whose address phase coincides with the data phase of a write to the same word therefore returns the value just written. The slave samples the bus-wide `hready_in` to know when an address phase may be taken, and it stretches its own data phases through `hreadyout`.

Top module: `ahb_posted_slave`

## Requirements
- R1: An address phase with `htrans` IDLE (2'b00) or BUSY (2'b01), or with `hsel` low, gets a zero-wait OKAY response and does not change the array.
- R2: An address phase is taken only on a rising edge where `hsel`, `hready_in` and `htrans[1]` are all high (NONSEQ 2'b10 or SEQ 2'b11). A transfer presented while `hready_in` is low is not performed.
- R3: A write with `hprot[2]`=1 that finds the buffer empty is posted to the buffer with `hreadyout` high throughout its data phase. A write with `hprot[2]`=0 is written to the array directly.
- R4: A write data phase, bufferable or not, that finds the buffer occupied gets exactly one wait state (`hreadyout` low for one cycle). The write data is taken on the edge that ends the data phase.
- R5: The buffer is written back in any cycle with no active data phase. A write issued after such a cycle gets no wait state.
- R6: Read data equals the latest write to that word, including bytes still held in the buffer. This includes a read whose address phase falls in the data phase of the write. A read of a different word while the buffer is occupied returns the array contents.
- R7: Writes update only the byte lanes selected by `hsize` and `haddr[1:0]`: size 0 writes lane `haddr[1:0]`, size 1 writes lanes 1:0 or 3:2 by `haddr[1]`, and size 2 writes all four lanes. Lane n is bits 8n+7:8n.
- R8: `hresp` is always 0 (OKAY). `hrdata` is zero in every cycle that is not a read data phase.
- R9: After reset `hreadyout` is 1, the buffer is empty and every array word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hsel | input | 1 | Slave select |
| haddr | input | AW | Byte address |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | 1 = write, 0 = read |
| hsize | input | 3 | Transfer size (0 byte, 1 halfword, 2 word) |
| hprot | input | 4 | Protection attributes; bit 2 = bufferable |
| hwdata | input | 32 | Write data |
| hready_in | input | 1 | Bus-wide ready fed back from the slave multiplexer |
| hreadyout | output | 1 | This slave's ready; low stretches its data phase |
| hresp | output | 1 | Response, always OKAY |
| hrdata | output | 32 | Read data |

## Verification
The bench chains back-to-back transfers so that each read address phase overlaps the data phase of a write to the same word. A design without forwarding would return the stale array value there. Two consecutive writes of each kind check that a full buffer adds exactly one wait state. A missing stall would lose or reorder data, and a stall that never releases would hang the bus. After an IDLE cycle a following write must get no wait state, which exposes write-back logic that only runs during stalls. A halfword overlay on top of a byte write, read back while still buffered, catches wrong lane masks or a forward path that replaces the whole word. A transfer offered while another slave holds `hready_in` low must leave memory untouched.

// File: rtl/ahb_posted_pkg.sv
package ahb_posted_pkg;

    localparam int LANES  = 4;
    localparam int WORD_W = 8 * LANES;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } trans_e;

    // Control captured in the address phase, carried into the data phase.
    typedef struct packed {
        logic       valid;
        logic       write;
        logic       bufable;
        logic [2:0] size;
        logic [1:0] off;
    } phase_t;

    function automatic logic [LANES-1:0] lane_mask(input logic [2:0] size,
                                                   input logic [1:0] off);
        logic [LANES-1:0] m;
        case (size)
            3'd0:    m = LANES'(1) << off;
            3'd1:    m = off[1] ? 4'b1100 : 4'b0011;
            default: m = '1;
        endcase
        return m;
    endfunction

    function automatic logic [WORD_W-1:0] overlay(input logic [WORD_W-1:0] base,
                                                  input logic [WORD_W-1:0] top,
                                                  input logic [LANES-1:0]  sel);
        logic [WORD_W-1:0] r;
        for (int b = 0; b < LANES; b++)
            r[8*b +: 8] = sel[b] ? top[8*b +: 8] : base[8*b +: 8];
        return r;
    endfunction

endpackage

// File: rtl/apw_store.sv
module apw_store
    import ahb_posted_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int IW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IW-1:0]     widx,
    input  logic [WORD_W-1:0] wdata,
    input  logic [LANES-1:0]  wmask,
    input  logic [IW-1:0]     ridx,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            for (int b = 0; b < LANES; b++)
                if (wmask[b]) mem[widx][8*b +: 8] <= wdata[8*b +: 8];
        end
    end

    assign rdata = mem[ridx];

endmodule

// File: rtl/apw_wbuf.sv
module apw_wbuf
    import ahb_posted_pkg::*;
#(
    parameter int IW = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [IW-1:0]     ld_idx,
    input  logic [WORD_W-1:0] ld_data,
    input  logic [LANES-1:0]  ld_mask,
    input  logic              drain,
    output logic              valid,
    output logic [IW-1:0]     idx,
    output logic [WORD_W-1:0] data,
    output logic [LANES-1:0]  mask
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            idx   <= '0;
            data  <= '0;
            mask  <= '0;
        end else if (load) begin
            valid <= 1'b1;
            idx   <= ld_idx;
            data  <= ld_data;
            mask  <= ld_mask;
        end else if (drain) begin
            valid <= 1'b0;
        end
    end

endmodule

// File: rtl/ahb_posted_slave.sv
module ahb_posted_slave
    import ahb_posted_pkg::*;
#(
    parameter  int AW    = 32,
    parameter  int DEPTH = 16,
    localparam int IW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hsel,
    input  logic [AW-1:0]     haddr,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic [2:0]        hsize,
    input  logic [3:0]        hprot,
    input  logic [WORD_W-1:0] hwdata,
    input  logic              hready_in,
    output logic              hreadyout,
    output logic              hresp,
    output logic [WORD_W-1:0] hrdata
);

    phase_t            dp;
    logic [IW-1:0]     dp_idx;
    logic              dp_valid, dp_write, dp_bufable;
    logic              take, stall, wr_done, direct_we, wb_load, wb_drain;
    logic              wb_valid;
    logic [IW-1:0]     wb_idx;
    logic [WORD_W-1:0] wb_data, st_rdata, st_wdata, fwd_data;
    logic [LANES-1:0]  wb_mask, dp_mask, st_wmask;
    logic [IW-1:0]     st_widx;
    logic              unused_bits;

    assign unused_bits = ^{hprot[3], hprot[1:0], haddr[AW-1:IW+2]};

    // Address phase capture.
    assign take = hsel && hready_in && htrans[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            dp     <= '0;
            dp_idx <= '0;
        end else if (hready_in) begin
            dp.valid   <= take;
            dp.write   <= hwrite;
            dp.bufable <= hprot[2];
            dp.size    <= hsize;
            dp.off     <= haddr[1:0];
            dp_idx     <= haddr[IW+1:2];
        end
    end

    assign dp_valid   = dp.valid;
    assign dp_write   = dp.write;
    assign dp_bufable = dp.bufable;
    assign dp_mask    = lane_mask(dp.size, dp.off);

    // Data phase control.
    assign stall     = dp.valid && dp.write && wb_valid;
    assign wr_done   = dp.valid && dp.write && !stall;
    assign direct_we = wr_done && !dp.bufable;
    assign wb_load   = wr_done && dp.bufable;
    assign wb_drain  = wb_valid && (!dp.valid || stall);

    apw_wbuf #(.IW(IW)) u_wbuf (
        .clk     (clk),
        .rst     (rst),
        .load    (wb_load),
        .ld_idx  (dp_idx),
        .ld_data (hwdata),
        .ld_mask (dp_mask),
        .drain   (wb_drain),
        .valid   (wb_valid),
        .idx     (wb_idx),
        .data    (wb_data),
        .mask    (wb_mask)
    );

    // Single array write port shared by direct writes and write-back.
    assign st_widx  = direct_we ? dp_idx  : wb_idx;
    assign st_wdata = direct_we ? hwdata  : wb_data;
    assign st_wmask = direct_we ? dp_mask : wb_mask;

    apw_store #(.DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (direct_we || wb_drain),
        .widx  (st_widx),
        .wdata (st_wdata),
        .wmask (st_wmask),
        .ridx  (dp_idx),
        .rdata (st_rdata)
    );

    // Read path snoops the buffer.
    assign fwd_data = (wb_valid && wb_idx == dp_idx)
                    ? overlay(st_rdata, wb_data, wb_mask) : st_rdata;

    assign hrdata    = (dp.valid && !dp.write) ? fwd_data : '0;
    assign hreadyout = !stall;
    assign hresp     = 1'b0;

endmodule

// File: rtl/ahb_posted_chk.sv
module ahb_posted_chk (
    input logic       clk,
    input logic       rst,
    input logic       hsel,
    input logic       hready_in,
    input logic [1:0] htrans,
    input logic       hreadyout,
    input logic       dp_valid,
    input logic       dp_write,
    input logic       dp_bufable,
    input logic       wb_valid
);

    assert_idle_ready_R1: assert property (@(posedge clk) disable iff (rst)
        (hsel && hready_in && !htrans[1]) |=> hreadyout);

    assert_no_take_R2: assert property (@(posedge clk) disable iff (rst)
        (hready_in && !(hsel && htrans[1])) |=> !dp_valid);

    assert_hold_phase_R2: assert property (@(posedge clk) disable iff (rst)
        !hready_in |=> $stable(dp_valid));

    assert_post_bufable_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(wb_valid) |-> $past(dp_bufable && dp_write));

    assert_single_wait_R4: assert property (@(posedge clk) disable iff (rst)
        !hreadyout |=> hreadyout);

    assert_stall_empties_R4: assert property (@(posedge clk) disable iff (rst)
        !hreadyout |=> !wb_valid);

    assert_idle_drain_R5: assert property (@(posedge clk) disable iff (rst)
        (!dp_valid && wb_valid) |=> !wb_valid);

endmodule

bind ahb_posted_slave ahb_posted_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .hsel       (hsel),
    .hready_in  (hready_in),
    .htrans     (htrans),
    .hreadyout  (hreadyout),
    .dp_valid   (dp_valid),
    .dp_write   (dp_write),
    .dp_bufable (dp_bufable),
    .wb_valid   (wb_valid)
);

// File: tb/ahb_posted_slave_test.sv
`timescale 1ns/1ps
module ahb_posted_slave_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hsel = 1'b0;
    logic [31:0] haddr = '0;
    logic [1:0]  htrans = 2'b00;
    logic        hwrite = 1'b0;
    logic [2:0]  hsize = 3'd2;
    logic [3:0]  hprot = 4'b0000;
    logic [31:0] hwdata = '0;
    logic        hready_in;
    logic        hreadyout;
    logic        hresp;
    logic [31:0] hrdata;
    logic        ext_stall = 1'b0;

    int          n_checks = 0;
    int          n_fail = 0;
    bit          ended = 1'b0;
    logic [7:0]  model [64];
    logic [31:0] pend_wdata = '0;
    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        rd_phase = 1'b0;
    int          w;

    always #2 clk = ~clk;

    assign hready_in = hreadyout && !ext_stall;

    ahb_posted_slave uut (
        .clk(clk), .rst(rst), .hsel(hsel), .haddr(haddr), .htrans(htrans),
        .hwrite(hwrite), .hsize(hsize), .hprot(hprot), .hwdata(hwdata),
        .hready_in(hready_in), .hreadyout(hreadyout), .hresp(hresp),
        .hrdata(hrdata)
    );

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    function automatic logic [31:0] model_word(input logic [31:0] a);
        logic [31:0] r;
        for (int b = 0; b < 4; b++) r[8*b +: 8] = model[{a[5:2], 2'(b)}];
        return r;
    endfunction

    // Driver: presents one address phase, returns waits seen by the prior data phase.
    task automatic xfer(input bit sel, input logic [1:0] tr, input bit wr,
                        input logic [2:0] sz, input bit bufb,
                        input logic [31:0] a, input logic [31:0] d,
                        output int waits);
        logic [3:0] m;
        @(negedge clk);
        hsel = sel; htrans = tr; hwrite = wr; hsize = sz;
        hprot = bufb ? 4'b0100 : 4'b0000; haddr = a; hwdata = pend_wdata;
        waits = 0;
        #1;
        while (!hready_in) begin
            waits++;
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        if (sel && tr[1]) begin
            if (wr) begin
                pend_wdata = d;
                case (sz)
                    3'd0:    m = 4'b0001 << a[1:0];
                    3'd1:    m = a[1] ? 4'b1100 : 4'b0011;
                    default: m = 4'b1111;
                endcase
                for (int b = 0; b < 4; b++)
                    if (m[b]) model[{a[5:2], 2'(b)}] = d[8*b +: 8];
            end else begin
                exp_q.push_back(model_word(a));
                tag_q.push_back("R6 read data");
            end
        end
    endtask

    // Monitor: tracks read data phases and compares against the scoreboard.
    always @(posedge clk) begin
        if (rst) rd_phase <= 1'b0;
        else if (hready_in) rd_phase <= hsel && htrans[1] && !hwrite;
    end

    always @(negedge clk) begin
        #1;
        if (!rst && !ended) begin
            check("R8 hresp", {31'b0, hresp}, 32'b0);
            if (rd_phase) begin
                if (hready_in) begin
                    if (exp_q.size() == 0) check("R6 unexpected read", hrdata, 32'hx);
                    else check(tag_q.pop_front(), hrdata, exp_q.pop_front());
                end
            end else begin
                check("R8 hrdata idle", hrdata, 32'h0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 64; i++) model[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R9 reset hreadyout", {31'b0, hreadyout}, 32'd1);
        check("R9 reset hresp", {31'b0, hresp}, 32'd0);
        check("R9 reset hrdata", hrdata, 32'd0);

        // R9: array cleared by reset
        xfer(1, 2'b10, 0, 3'd2, 0, 32'h00, 0, w);
        xfer(1, 2'b10, 0, 3'd2, 0, 32'h3C, 0, w);

        // R3 / R4 / R6: direct then posted writes, same-cycle read
        xfer(1, 2'b10, 1, 3'd2, 0, 32'h10, 32'h11223344, w);
        xfer(1, 2'b10, 1, 3'd2, 1, 32'h14, 32'h55667788, w);
        check("R3 direct write waits", w, 0);
        xfer(1, 2'b10, 0, 3'd2, 0, 32'h14, 0, w);
        check("R3 posted write zero wait", w, 0);
        xfer(1, 2'b11, 1, 3'd2, 1, 32'h18, 32'h99AABBCC, w);
        xfer(1, 2'b10, 0, 3'd2, 0, 32'h14, 0, w);
        check("R4 posted write into full buffer", w, 1);
        xfer(1, 2'b10, 0, 3'd2, 0, 32'h18, 0, w);

        // R5: an idle cycle drains the buffer
        xfer(1, 2'b00, 0, 3'd2, 0, 32'h00, 0, w);
        xfer(1, 2'b10, 1, 3'd2, 1, 32'h1C, 32'h0BADF00D, w);
        xfer(1, 2'b10, 0, 3'd2, 0, 32'h1C, 0, w);
        check("R5 write after idle cycle", w, 0);

        // R7 / R4: lanes; direct write meets a full buffer
        xfer(1, 2'b10, 1, 3'd2, 0, 32'h20, 32'hAABBCCDD, w);
        xfer(1, 2'b10, 1, 3'd0, 0, 32'h21, 32'h00005500, w);
        check("R4 direct write into full buffer", w, 1);
        xfer(1, 2'b10, 1, 3'd1, 1, 32'h22, 32'h12340000, w);
        xfer(1, 2'b10, 0, 3'd2, 0, 32'h20, 0, w);
        check("R7 lane model", model_word(32'h20), 32'h123455DD);
        xfer(1, 2'b10, 0, 3'd2, 0, 32'h10, 0, w);

        // R1: BUSY and deselected transfers do nothing
        xfer(1, 2'b01, 1, 3'd2, 1, 32'h20, 32'hFFFFFFFF, w);
        xfer(0, 2'b10, 1, 3'd2, 0, 32'h20, 32'hFFFFFFFF, w);
        check("R1 busy zero wait", w, 0);
        xfer(1, 2'b10, 0, 3'd2, 0, 32'h20, 0, w);
        check("R1 deselected zero wait", w, 0);
        xfer(1, 2'b00, 0, 3'd2, 0, 32'h00, 0, w);

        // R2: transfer offered while another slave holds hready low
        @(negedge clk);
        ext_stall = 1'b1;
        hsel = 1'b1; htrans = 2'b10; hwrite = 1'b1; hsize = 3'd2;
        hprot = 4'b0000; haddr = 32'h24;
        @(negedge clk);
        #1;
        check("R2 ready held while bus waits", {31'b0, hreadyout}, 32'd1);
        ext_stall = 1'b0;
        hsel = 1'b0; htrans = 2'b00; hwdata = 32'hDEADBEEF;
        xfer(1, 2'b10, 0, 3'd2, 0, 32'h24, 0, w);

        // R4: non-bufferable write right behind a posted one
        xfer(1, 2'b10, 1, 3'd2, 1, 32'h30, 32'hCAFEBABE, w);
        xfer(1, 2'b10, 1, 3'd2, 0, 32'h34, 32'h01020304, w);
        check("R4 posted write into empty buffer", w, 0);
        xfer(1, 2'b10, 0, 3'd2, 0, 32'h30, 0, w);
        check("R4 direct write behind posted", w, 1);
        xfer(1, 2'b10, 0, 3'd2, 0, 32'h34, 0, w);
        xfer(1, 2'b00, 0, 3'd2, 0, 32'h00, 0, w);
        xfer(1, 2'b00, 0, 3'd2, 0, 32'h00, 0, w);

        check("R6 all reads compared", exp_q.size(), 0);
        finish_run();
    end

endmodule